// File: doc/BRIEF.md
# Configurable GPIO Bank

This block is one bank of up to eight general-purpose pins that sit in an I/O-mapped register space. The bank has one shared level register. Each pin also has its own configuration byte, and that byte has its own address. The configuration byte chooses whether the pin drives or senses, whether its polarity is flipped, and whether it drives actively in both directions or only pulls low. Pins that the bank does not implement are declared by giving them a configuration address of zero. Such a pin has no storage, never answers an access and never drives its pad.

A host uses one request port and gives a register offset. Writes take effect at the clock edge where the request is sampled. Reads return their data and a hit flag on the next cycle. To change a single output, the host reads the level register, changes one bit and writes the byte back. Pad inputs pass through a two-flop synchronizer before they can be read. The pad outputs are a level and an enable for each pin, and they are meant to drive a bidirectional buffer outside the block.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset, every implemented pin is an input with no inversion and push-pull drive, and its output latch is 0. Its configuration byte reads 0x01 and every pad_oe bit is 0.
- R2: In a configuration byte, bit 0 set means input and clear means output. Bit 1 set inverts polarity. Bit 7 set selects open-drain drive and clear selects push-pull. All other bits read as 0.
- R3: An access decodes only at DATA_ADDR or at a nonzero entry of the pin address table. Any other address, including 0, returns rd_hit 0 and rd_data 0x00, and a write to it changes no state.
- R4: For a read request sampled at a clock edge, rd_data and rd_hit are valid after that same edge. rd_hit is 0 in every cycle that does not follow a read request.
- R5: The level register reads bit N from pin N. For an input pin this is the synchronized pad level XOR the invert bit. For an output pin it is the output latch. For an absent pin, and for bits at or above NPIN, it is 0.
- R6: A write to the level register loads bit N into the output latch of implemented pin N.
- R7: A push-pull output pin has pad_oe 1 and pad_out equal to its latch XOR its invert bit.
- R8: An open-drain output pin has pad_out 0. Its pad_oe is 1 when latch XOR invert is 0, and 0 when that value is 1.
- R9: An input pin has pad_oe 0 and pad_out 0. Its latch keeps its value across direction changes.
- R10: A pad level that changes just after edge k is not seen by a read sampled at edge k+2. It is seen by a read sampled at edge k+3 or later.
- R11: Absent pins always have pad_oe 0 and pad_out 0. Their bits in the level register ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Register offset |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the request |
| rd_hit | output | 1 | Read address decoded, one cycle after the request |
| pad_in | input | NPIN | Asynchronous pad levels |
| pad_out | output | NPIN | Level driven toward each pad |
| pad_oe | output | NPIN | Drive enable for each pad |

## Verification
The assertions assume the following about the inputs. req_write is meaningful only while req_valid is high. pad_in can change at any time, because only its synchronized copy is ever checked. The address table holds no duplicates and does not hold DATA_ADDR. The stimulus respects these assumptions: it uses the default table, which is free of collisions, and it changes requests and pad levels only at falling edges, one request at a time. Address sweeps cover the whole AW space, so each miss is a real miss and not an overlap.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned CFG_DIR_B  = 0;
   localparam int unsigned CFG_INV_B  = 1;
   localparam int unsigned CFG_OD_B   = 7;

   typedef struct packed {
      logic od;    // 1 = open-drain
      logic inv;   // 1 = polarity inverted
      logic dir;   // 1 = input
   } pin_cfg_t;

   localparam pin_cfg_t CFG_RESET = '{od: 1'b0, inv: 1'b0, dir: 1'b1};

   function automatic logic [BYTE_W-1:0] cfg_to_byte(input pin_cfg_t c);
      logic [BYTE_W-1:0] b;
      b = '0;
      b[CFG_DIR_B] = c.dir;
      b[CFG_INV_B] = c.inv;
      b[CFG_OD_B]  = c.od;
      return b;
   endfunction

   function automatic pin_cfg_t byte_to_cfg(input logic [BYTE_W-1:0] b);
      pin_cfg_t c;
      c.dir = b[CFG_DIR_B];
      c.inv = b[CFG_INV_B];
      c.od  = b[CFG_OD_B];
      return c;
   endfunction
endpackage

// File: rtl/gpb_decode.sv
module gpb_decode #(
   parameter int unsigned        NPIN      = 8,
   parameter int unsigned        AW        = 8,
   parameter logic [AW-1:0]      DATA_ADDR = 8'h4E,
   parameter logic [NPIN*AW-1:0] CFG_ADDRS = '0
) (
   input  logic [AW-1:0]   addr,
   output logic            data_sel,
   output logic [NPIN-1:0] cfg_sel
);
   assign data_sel = (addr == DATA_ADDR);

   for (genvar i = 0; i < NPIN; i++) begin : g_sel
      localparam logic [AW-1:0] ENTRY = CFG_ADDRS[i*AW +: AW];
      if (ENTRY == '0) begin : g_absent
         assign cfg_sel[i] = 1'b0;
      end else begin : g_present
         assign cfg_sel[i] = (addr == ENTRY);
      end
   end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   if (STAGES < 2) begin : g_bad_depth
      $error("gpb_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpb_pin.sv
module gpb_pin
   import gpb_pkg::*;
#(
   parameter bit PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              data_we,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              wr_bit,
   input  logic              sync_lvl,
   output logic [BYTE_W-1:0] cfg_byte,
   output logic              rd_bit,
   output logic              pad_out,
   output logic              pad_oe
);
   if (PRESENT) begin : g_present
      pin_cfg_t cfg_q;
      logic     latch_q;
      logic     drive;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q   <= CFG_RESET;
            latch_q <= 1'b0;
         end else begin
            if (cfg_we)  cfg_q   <= byte_to_cfg(wr_byte);
            if (data_we) latch_q <= wr_bit;
         end
      end

      assign drive = latch_q ^ cfg_q.inv;

      always_comb begin
         if (cfg_q.dir) begin
            pad_oe  = 1'b0;
            pad_out = 1'b0;
         end else if (cfg_q.od) begin
            pad_oe  = ~drive;
            pad_out = 1'b0;
         end else begin
            pad_oe  = 1'b1;
            pad_out = drive;
         end
      end

      assign rd_bit   = cfg_q.dir ? (sync_lvl ^ cfg_q.inv) : latch_q;
      assign cfg_byte = cfg_to_byte(cfg_q);
   end else begin : g_absent
      logic unused_absent;
      assign unused_absent = ^{clk, rst_n, cfg_we, data_we, wr_byte, wr_bit, sync_lvl};
      assign cfg_byte = '0;
      assign rd_bit   = 1'b0;
      assign pad_out  = 1'b0;
      assign pad_oe   = 1'b0;
   end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
   import gpb_pkg::*;
#(
   parameter int unsigned        NPIN        = 8,
   parameter int unsigned        AW          = 8,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [AW-1:0]      DATA_ADDR   = 8'h4E,
   parameter logic [NPIN*AW-1:0] CFG_ADDRS   =
      {8'h73, 8'h72, 8'h6F, 8'h6E, 8'h00, 8'h3D, 8'h00, 8'h3B}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [7:0]      req_wdata,
   output logic [7:0]      rd_data,
   output logic            rd_hit,
   input  logic [NPIN-1:0] pad_in,
   output logic [NPIN-1:0] pad_out,
   output logic [NPIN-1:0] pad_oe
);
   if (NPIN < 1 || NPIN > BYTE_W) begin : g_bad_npin
      $error("gpio_cfg_bank: NPIN must be 1..8");
   end
   if (DATA_ADDR == '0) begin : g_bad_data_addr
      $error("gpio_cfg_bank: DATA_ADDR must be nonzero");
   end

   logic              data_sel;
   logic [NPIN-1:0]   cfg_sel;
   logic [NPIN-1:0]   pad_sync;
   logic [NPIN-1:0]   pin_rd;
   logic [BYTE_W-1:0] cfg_bytes [NPIN];
   logic              wr_go;
   logic              rd_go;
   logic [BYTE_W-1:0] rd_mux;

   assign wr_go = req_valid &  req_write;
   assign rd_go = req_valid & ~req_write;

   gpb_decode #(
      .NPIN(NPIN), .AW(AW), .DATA_ADDR(DATA_ADDR), .CFG_ADDRS(CFG_ADDRS)
   ) decode_i (
      .addr(req_addr), .data_sel(data_sel), .cfg_sel(cfg_sel)
   );

   gpb_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
   );

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      gpb_pin #(.PRESENT(CFG_ADDRS[i*AW +: AW] != '0)) pin_i (
         .clk(clk),
         .rst_n(rst_n),
         .cfg_we(wr_go & cfg_sel[i]),
         .data_we(wr_go & data_sel),
         .wr_byte(req_wdata),
         .wr_bit(req_wdata[i]),
         .sync_lvl(pad_sync[i]),
         .cfg_byte(cfg_bytes[i]),
         .rd_bit(pin_rd[i]),
         .pad_out(pad_out[i]),
         .pad_oe(pad_oe[i])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (data_sel) begin
         for (int i = 0; i < NPIN; i++) rd_mux[i] = pin_rd[i];
      end
      for (int i = 0; i < NPIN; i++) begin
         if (cfg_sel[i]) rd_mux = rd_mux | cfg_bytes[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_hit  <= 1'b0;
      end else begin
         rd_data <= rd_go ? rd_mux : '0;
         rd_hit  <= rd_go & (data_sel | (|cfg_sel));
      end
   end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
   parameter int unsigned        NPIN      = 8,
   parameter int unsigned        AW        = 8,
   parameter logic [AW-1:0]      DATA_ADDR = 8'h4E,
   parameter logic [NPIN*AW-1:0] CFG_ADDRS = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_write,
   input logic [AW-1:0]   req_addr,
   input logic [7:0]      rd_data,
   input logic            rd_hit,
   input logic [NPIN-1:0] pad_out,
   input logic [NPIN-1:0] pad_oe
);
   function automatic logic [NPIN-1:0] present_mask();
      logic [NPIN-1:0] m;
      for (int i = 0; i < NPIN; i++) m[i] = (CFG_ADDRS[i*AW +: AW] != '0);
      return m;
   endfunction

   function automatic logic mapped(input logic [AW-1:0] a);
      logic h;
      h = (a == DATA_ADDR);
      for (int i = 0; i < NPIN; i++)
         if (CFG_ADDRS[i*AW +: AW] != '0 && CFG_ADDRS[i*AW +: AW] == a) h = 1'b1;
      return h;
   endfunction

   localparam logic [NPIN-1:0] PRESENT = present_mask();

   // R1: reset leaves every pad undriven
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> pad_oe == '0);

   // R11: absent pins never drive
   a_r11_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | pad_out) & ~PRESENT) == '0);

   // R8/R9: a high level only ever appears on an enabled pad
   a_r8_high_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   // R3: unmapped reads never hit and return zero
   a_r3_miss_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !mapped(req_addr)) |=> (!rd_hit && rd_data == '0));

   // R3: unmapped writes leave the pads untouched
   a_r3_miss_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !mapped(req_addr)) |=> ($stable(pad_out) && $stable(pad_oe)));

   // R4: a hit only follows a read request
   a_r4_hit_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> $past(req_valid && !req_write));

   // R6: pad controls move only after a write
   a_r6_pads_need_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid && req_write) |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_cfg_bank gpb_checker #(
   .NPIN(NPIN), .AW(AW), .DATA_ADDR(DATA_ADDR), .CFG_ADDRS(CFG_ADDRS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .rd_data(rd_data), .rd_hit(rd_hit),
   .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_cfg_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_cfg_bank_tb_top;
   localparam int unsigned  NPIN = 8;
   localparam int unsigned  AW   = 8;
   localparam logic [7:0]   DADDR = 8'h4E;
   localparam logic [63:0]  TABLE =
      {8'h73, 8'h72, 8'h6F, 8'h6E, 8'h00, 8'h3D, 8'h00, 8'h3B};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [7:0] req_addr = '0, req_wdata = '0;
   logic [7:0] rd_data;
   logic rd_hit;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_out, pad_oe;

   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   gpio_cfg_bank #(.NPIN(NPIN), .AW(AW), .DATA_ADDR(DADDR), .CFG_ADDRS(TABLE)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .rd_hit(rd_hit),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   function automatic logic [7:0] mask();
      logic [7:0] m;
      for (int i = 0; i < 8; i++) m[i] = (TABLE[i*8 +: 8] != 8'h00);
      return m;
   endfunction
   localparam logic [7:0] MASK = mask();

   function automatic logic is_mapped(input logic [7:0] a);
      logic h;
      h = (a == DADDR);
      for (int i = 0; i < 8; i++)
         if (TABLE[i*8 +: 8] != 8'h00 && TABLE[i*8 +: 8] == a) h = 1'b1;
      return h;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic h);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      d = rd_data; h = rd_hit;
   endtask

   task automatic cfg_all(input logic [7:0] b);
      for (int i = 0; i < 8; i++)
         if (TABLE[i*8 +: 8] != 8'h00) wr(TABLE[i*8 +: 8], b);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 pad_oe", {8'h0, pad_oe}, 16'h0);
      check("R1 pad_out", {8'h0, pad_out}, 16'h0);
      for (int i = 0; i < 8; i++)
         if (TABLE[i*8 +: 8] != 8'h00) begin
            rd(TABLE[i*8 +: 8], d, h);
            check("R1 cfg reset", {7'h0, h, d}, {7'h0, 1'b1, 8'h01});
         end

      // R3 R4: full address sweep of reads
      for (int a = 0; a < 256; a++) begin
         rd(a[7:0], d, h);
         check("R3 hit", {15'h0, h}, {15'h0, is_mapped(a[7:0])});
         if (!is_mapped(a[7:0])) check("R3 miss data", {8'h0, d}, 16'h0);
      end
      @(negedge clk);
      check("R4 idle no hit", {15'h0, rd_hit}, 16'h0);

      // R5 R10: input sweep, non-inverted then inverted
      for (int inv = 0; inv < 2; inv++) begin
         cfg_all(inv ? 8'h03 : 8'h01);
         for (int p = 0; p < 256; p++) begin
            @(negedge clk); pad_in = p[7:0];
            @(negedge clk);
            rd(DADDR, d, h);
            check(inv ? "R5 input inverted" : "R5 input plain", {8'h0, d},
                  {8'h0, (inv ? ~p[7:0] : p[7:0]) & MASK});
         end
      end

      // R10: synchronizer latency
      cfg_all(8'h01);
      @(negedge clk); pad_in = 8'h00;
      repeat (4) @(negedge clk);
      pad_in = 8'hFF;
      rd(DADDR, d, h);
      check("R10 not yet visible", {8'h0, d}, 16'h0);
      @(negedge clk); pad_in = 8'h00;
      repeat (4) @(negedge clk);
      pad_in = 8'hFF;
      @(negedge clk);
      rd(DADDR, d, h);
      check("R10 visible", {8'h0, d}, {8'h0, MASK});

      // R2: config byte fields
      wr(TABLE[0 +: 8], 8'hFF);
      rd(TABLE[0 +: 8], d, h);
      check("R2 cfg fields", {8'h0, d}, 16'h0083);
      wr(TABLE[0 +: 8], 8'h7C);
      rd(TABLE[0 +: 8], d, h);
      check("R2 cfg other bits", {8'h0, d}, 16'h0000);

      // R6 R7 R11: push-pull outputs, plain and inverted
      for (int inv = 0; inv < 2; inv++) begin
         cfg_all(inv ? 8'h02 : 8'h00);
         for (int v = 0; v < 256; v++) begin
            wr(DADDR, v[7:0]);
            check("R7 oe", {8'h0, pad_oe}, {8'h0, MASK});
            check(inv ? "R7 out inverted" : "R7 out", {8'h0, pad_out},
                  {8'h0, (inv ? ~v[7:0] : v[7:0]) & MASK});
            rd(DADDR, d, h);
            check("R6 latch readback", {8'h0, d}, {8'h0, v[7:0] & MASK});
         end
      end

      // R8 R11: open-drain
      cfg_all(8'h80);
      for (int v = 0; v < 256; v++) begin
         wr(DADDR, v[7:0]);
         check("R8 od out", {8'h0, pad_out}, 16'h0);
         check("R8 od oe", {8'h0, pad_oe}, {8'h0, ~v[7:0] & MASK});
      end
      cfg_all(8'h82);
      wr(DADDR, 8'h0F);
      check("R8 od inverted oe", {8'h0, pad_oe}, {8'h0, 8'h0F & MASK});

      // R5: mixed directions, output read returns latch regardless of invert
      cfg_all(8'h01);
      wr(TABLE[0 +: 8], 8'h02);
      wr(TABLE[4*8 +: 8], 8'h00);
      wr(DADDR, 8'hFF);
      @(negedge clk); pad_in = 8'h00;
      repeat (3) @(negedge clk);
      rd(DADDR, d, h);
      check("R5 mixed", {8'h0, d}, 16'h0011);

      // R9: input retains latch
      cfg_all(8'h00);
      wr(DADDR, 8'hA5);
      cfg_all(8'h01);
      check("R9 input oe", {8'h0, pad_oe}, 16'h0);
      check("R9 input out", {8'h0, pad_out}, 16'h0);
      cfg_all(8'h00);
      check("R9 latch kept", {8'h0, pad_out}, {8'h0, 8'hA5 & MASK});

      // R3: unmapped write changes nothing
      wr(8'h3C, 8'h81);
      wr(8'h00, 8'h81);
      for (int i = 0; i < 8; i++)
         if (TABLE[i*8 +: 8] != 8'h00) begin
            rd(TABLE[i*8 +: 8], d, h);
            check("R3 miss write", {8'h0, d}, 16'h0);
         end
      check("R3 pads unchanged", {pad_oe, pad_out}, {MASK, 8'hA5 & MASK});

      // R11: absent bits ignore writes
      wr(DADDR, 8'hFF);
      rd(DADDR, d, h);
      check("R11 absent bits", {8'h0, d & ~MASK}, 16'h0);
      check("R11 absent pads", {8'h0, (pad_oe | pad_out) & ~MASK}, 16'h0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule